// File: doc/BRIEF.md
# Multiplexed-Address Single-Bit DRAM Core

This block models the control side of a by-one dynamic memory whose cell address arrives in two halves over one narrow address bus. A row half is taken when the row strobe goes low, and a column half is taken when the column strobe goes low while the row is open. The state of the write-enable pin at that column edge decides the kind of cycle: a read, an early write, or a read that can turn into a late write. All strobes are active low and are sampled on a system clock. An edge is seen when one sample differs from the sample before it.

The single data output has its own enable. That enable is what the surrounding logic would use to drive or release a shared data pin. The output floats during early writes and row-only refresh cycles, and whenever the column strobe is high. During a read it drives the cell content, and it keeps that value while the column strobe stays low, even after the row strobe has closed. The storage array is reduced by folding: each address half is XOR-folded down to a parameter width, so a small array can be used while every address bit still takes part in selecting a cell.

The controller has six states:
- ST_IDLE: no row is open.
- ST_ROW_OPEN: a row is latched and the controller waits for a column edge. Closing the row from here is a refresh.
- ST_READ: the output drives the data that was read.
- ST_EARLY_WR: a write whose enable was low at the column edge.
- ST_LATE_WR: a read cycle that was later written through a falling write-enable.
- ST_HOLD: the row strobe is closed but the column strobe is still low, so the output is held.

The transitions are:
- ST_IDLE to ST_ROW_OPEN on a row strobe fall.
- ST_ROW_OPEN to ST_READ or to ST_EARLY_WR on a column strobe fall, chosen by the write-enable pin.
- ST_ROW_OPEN to ST_IDLE when the row strobe rises; this is a refresh.
- ST_READ to ST_LATE_WR on a write-enable fall.
- ST_READ and ST_LATE_WR to ST_HOLD when the row strobe rises while the column strobe is still low.
- ST_EARLY_WR to ST_IDLE when the row strobe rises.
- Any column-active state, ST_HOLD included, to ST_ROW_OPEN when the column strobe rises with the row still low. This is the page-mode path.
- Any column-active state, ST_HOLD included, to ST_IDLE when the column strobe rises with the row already high.
- Inside ST_HOLD, a row strobe fall latches a new row address. This is a hidden refresh.

Top module: `mux_dram_core`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `rdata_oe` and `rdata` are 0. After reset a column strobe fall with the row strobe high produces no output.
- R2: The row half is captured from `mux_addr` on the clock where `row_stb_n` is first sampled low. The column half is captured on the clock where `col_stb_n` is first sampled low while the row is open. The two halves together select one cell.
- R3: A column fall with `wr_en_n` sampled high is a read. At that same clock edge `rdata_oe` rises and `rdata` takes the selected cell's value.
- R4: A column fall with `wr_en_n` sampled low is an early write. `wdata` is stored in the selected cell, and `rdata_oe` stays 0 for the whole cycle.
- R5: At each clock edge where `col_stb_n` is sampled high, `rdata_oe` becomes 0.
- R6: While `col_stb_n` stays low, a driven output keeps its value, even when `row_stb_n` rises or falls again.
- R7: In a read cycle, a `wr_en_n` fall while both strobes are low writes `wdata` into the cell. The output keeps driving the value read earlier.
- R8: A cycle in which the row strobe goes low and returns high without a column edge drives no output and changes no cell, whatever the state of `wr_en_n` and `wdata`.
- R9: Several column strobe pulses inside one low row-strobe period each access a new column of the same row.
- R10: A column strobe fall while the row strobe is high writes nothing and drives nothing.
- R11: The cell row index is the XOR of the row half's ROW_KEEP-bit chunks. The column index is formed the same way with COL_KEEP. Addresses that fold to the same pair reach the same cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low (high = read) |
| mux_addr | input | ADDR_W (9) | Multiplexed row/column address |
| wdata | input | 1 | Write data bit |
| rdata | output | 1 | Read data bit |
| rdata_oe | output | 1 | Output drive enable for `rdata` |

## Verification
The bench builds the core with ADDR_W = 9 and ROW_KEEP = COL_KEEP = 4, which gives a 256-cell array. With these values, small row and column numbers map straight to distinct cells. A row of 0x15 and a column of 0x17 fold onto the same cell as row 4 and column 6, so aliasing under the XOR fold can be reached with one write and one read. The chosen values also allow an early write, a late write and a refresh to target cells already seeded with known contents, so that each effect shows at the output.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_OPEN,
        ST_READ,
        ST_EARLY_WR,
        ST_LATE_WR,
        ST_HOLD
    } dram_state_t;

    localparam int STB_ROW = 0;
    localparam int STB_COL = 1;
    localparam int STB_WR  = 2;
    localparam int NUM_STB = 3;

endpackage

// File: rtl/mdram_edge_det.sv
module mdram_edge_det #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_n,
    output logic [W-1:0] fall_p
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= lvl_n;
        end
    end

    generate
        for (genvar g = 0; g < W; g++) begin : g_fall
            assign fall_p[g] = prev_q[g] & ~lvl_n[g];
        end
    endgenerate

endmodule

// File: rtl/mdram_addr_latch.sv
module mdram_addr_latch #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_le,
    input  logic          col_le,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] row_q,
    output logic [AW-1:0] col_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (row_le) row_q <= addr_in;
            if (col_le) col_q <= addr_in;
        end
    end

endmodule

// File: rtl/mdram_cell_array.sv
module mdram_cell_array #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    localparam int DEPTH = 1 << IDX_W;

    logic cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_idx] <= wr_bit;
    end

    assign rd_bit = cells[rd_idx];

endmodule

// File: rtl/mux_dram_core.sv
module mux_dram_core
    import mux_dram_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int ROW_KEEP = 5,
    parameter int COL_KEEP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] mux_addr,
    input  logic              wdata,
    output logic              rdata,
    output logic              rdata_oe
);

    localparam int IDX_W = ROW_KEEP + COL_KEEP;

    // XOR-fold one address half down to the kept width
    function automatic logic [ROW_KEEP-1:0] fold_row(input logic [ADDR_W-1:0] a);
        logic [ROW_KEEP-1:0] r;
        r = '0;
        for (int i = 0; i < ADDR_W; i++) r[i % ROW_KEEP] = r[i % ROW_KEEP] ^ a[i];
        return r;
    endfunction

    function automatic logic [COL_KEEP-1:0] fold_col(input logic [ADDR_W-1:0] a);
        logic [COL_KEEP-1:0] r;
        r = '0;
        for (int i = 0; i < ADDR_W; i++) r[i % COL_KEEP] = r[i % COL_KEEP] ^ a[i];
        return r;
    endfunction

    dram_state_t state_q, state_d;

    logic [NUM_STB-1:0] fall_p;
    logic               row_fall, col_fall, wr_fall;
    logic               row_le, col_le;
    logic               wr_en, wr_from_pins;
    logic [ADDR_W-1:0]  row_q, col_q;
    logic [IDX_W-1:0]   pin_idx, held_idx, wr_idx;
    logic               rd_bit;

    mdram_edge_det #(.W(NUM_STB)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_n  ({wr_en_n, col_stb_n, row_stb_n}),
        .fall_p (fall_p)
    );

    assign row_fall = fall_p[STB_ROW];
    assign col_fall = fall_p[STB_COL];
    assign wr_fall  = fall_p[STB_WR];

    mdram_addr_latch #(.AW(ADDR_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_le  (row_le),
        .col_le  (col_le),
        .addr_in (mux_addr),
        .row_q   (row_q),
        .col_q   (col_q)
    );

    assign pin_idx  = {fold_row(row_q), fold_col(mux_addr)};
    assign held_idx = {fold_row(row_q), fold_col(col_q)};
    assign wr_idx   = wr_from_pins ? pin_idx : held_idx;

    mdram_cell_array #(.IDX_W(IDX_W)) u_cells (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_bit (wdata),
        .rd_idx (pin_idx),
        .rd_bit (rd_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and cycle actions
    always_comb begin
        state_d      = state_q;
        row_le       = 1'b0;
        col_le       = 1'b0;
        wr_en        = 1'b0;
        wr_from_pins = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (row_fall) begin
                    row_le  = 1'b1;
                    state_d = ST_ROW_OPEN;
                end
            end
            ST_ROW_OPEN: begin
                if (row_stb_n) begin
                    state_d = ST_IDLE;
                end else if (col_fall) begin
                    col_le = 1'b1;
                    if (!wr_en_n) begin
                        wr_en        = 1'b1;
                        wr_from_pins = 1'b1;
                        state_d      = ST_EARLY_WR;
                    end else begin
                        state_d = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (col_stb_n) begin
                    state_d = row_stb_n ? ST_IDLE : ST_ROW_OPEN;
                end else if (row_stb_n) begin
                    state_d = ST_HOLD;
                end else if (wr_fall) begin
                    wr_en   = 1'b1;
                    state_d = ST_LATE_WR;
                end
            end
            ST_EARLY_WR: begin
                if (col_stb_n) begin
                    state_d = row_stb_n ? ST_IDLE : ST_ROW_OPEN;
                end else if (row_stb_n) begin
                    state_d = ST_IDLE;
                end
            end
            ST_LATE_WR: begin
                if (col_stb_n) begin
                    state_d = row_stb_n ? ST_IDLE : ST_ROW_OPEN;
                end else if (row_stb_n) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (col_stb_n) begin
                    state_d = row_stb_n ? ST_IDLE : ST_ROW_OPEN;
                end else if (row_fall) begin
                    row_le = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered output drive and data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_oe <= 1'b0;
            rdata    <= 1'b0;
        end else begin
            rdata_oe <= (state_d == ST_READ) || (state_d == ST_LATE_WR) ||
                        (state_d == ST_HOLD);
            if ((state_q == ST_ROW_OPEN) && (state_d == ST_READ)) begin
                rdata <= rd_bit;
            end
        end
    end

endmodule

// File: rtl/mux_dram_checker.sv
module mux_dram_checker (
    input logic clk,
    input logic rst_n,
    input logic row_stb_n,
    input logic col_stb_n,
    input logic wr_en_n,
    input logic rdata,
    input logic rdata_oe
);

    AST_OE_OFF_COL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        col_stb_n |=> !rdata_oe); // R5

    AST_EARLY_WR_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(col_stb_n) && !row_stb_n && !wr_en_n) |=> !rdata_oe); // R4

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(col_stb_n) && !row_stb_n && !$past(row_stb_n) && wr_en_n) |=> rdata_oe); // R3

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && !col_stb_n) |=> $stable(rdata)); // R6

    AST_NO_DRIVE_ROW_HIGH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(col_stb_n) && row_stb_n && !rdata_oe) |=> !rdata_oe); // R10

endmodule

bind mux_dram_core mux_dram_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_stb_n (row_stb_n),
    .col_stb_n (col_stb_n),
    .wr_en_n   (wr_en_n),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe)
);

// File: tb/tb_mux_dram_core.sv
module tb_mux_dram_core;

    localparam int ADDR_W   = 9;
    localparam int ROW_KEEP = 4;
    localparam int COL_KEEP = 4;
    localparam int NVEC     = 48;

    // Vector layout: [19] row [18] col [17] wr [16:8] addr [7] wdata
    //                [6] exp_oe [5] exp_data [4] check_data [3:0] req
    function automatic logic [19:0] v(input logic r, input logic c, input logic w,
                                      input logic [8:0] a, input logic d,
                                      input logic eo, input logic ed,
                                      input logic cd, input logic [3:0] rq);
        return {r, c, w, a, d, eo, ed, cd, rq};
    endfunction

    localparam logic [19:0] VEC [NVEC] = '{
        v(1,1,1,9'd0,0,0,0,0,4'd1),    // R1 idle
        v(0,1,1,9'd5,0,0,0,0,4'd2),    // R2 open row 5
        v(0,0,0,9'd7,1,0,0,0,4'd4),    // R4 early write 1 to (5,7)
        v(0,0,1,9'd7,0,0,0,0,4'd4),    // R4 still floating
        v(1,1,1,9'd0,0,0,0,0,4'd5),
        v(0,1,1,9'd6,0,0,0,0,4'd2),    // R2 open row 6
        v(0,0,0,9'd7,0,0,0,0,4'd4),    // R4 early write 0 to (6,7)
        v(1,1,1,9'd0,0,0,0,0,4'd5),
        v(0,1,1,9'd5,0,0,0,0,4'd2),
        v(0,0,1,9'd7,0,1,1,1,4'd3),    // R3 read (5,7)=1
        v(1,0,1,9'd7,0,1,1,1,4'd6),    // R6 row closes, data held
        v(1,1,1,9'd0,0,0,0,0,4'd5),    // R5 col high floats
        v(0,1,1,9'd6,0,0,0,0,4'd2),
        v(0,0,1,9'd7,0,1,0,1,4'd2),    // R2 read (6,7)=0
        v(0,1,1,9'd7,0,0,0,0,4'd5),    // R5 page gap
        v(0,0,0,9'd9,1,0,0,0,4'd4),    // R4 page early write 1 to (6,9)
        v(0,1,1,9'd9,0,0,0,0,4'd5),
        v(0,0,1,9'd7,0,1,0,1,4'd9),    // R9 page read (6,7)=0
        v(0,1,1,9'd7,0,0,0,0,4'd5),
        v(0,0,1,9'd9,0,1,1,1,4'd9),    // R9 page read (6,9)=1
        v(0,0,0,9'd9,0,1,1,1,4'd7),    // R7 late write 0, old data stays
        v(0,0,0,9'd9,0,1,1,1,4'd7),
        v(1,1,1,9'd0,0,0,0,0,4'd5),
        v(0,1,1,9'd6,0,0,0,0,4'd2),
        v(0,0,1,9'd9,0,1,0,1,4'd7),    // R7 late write landed
        v(1,1,1,9'd0,0,0,0,0,4'd5),
        v(0,1,0,9'd5,0,0,0,0,4'd8),    // R8 row-only refresh
        v(0,1,0,9'd5,0,0,0,0,4'd8),
        v(1,1,1,9'd0,0,0,0,0,4'd8),
        v(0,1,1,9'd5,0,0,0,0,4'd2),
        v(0,0,1,9'd7,0,1,1,1,4'd8),    // R8 (5,7) unchanged
        v(1,1,1,9'd0,0,0,0,0,4'd5),
        v(1,0,0,9'd7,0,0,0,0,4'd10),   // R10 col fall with row high
        v(1,1,1,9'd0,0,0,0,0,4'd10),
        v(0,1,1,9'd5,0,0,0,0,4'd2),
        v(0,0,1,9'd7,0,1,1,1,4'd10),   // R10 no write happened
        v(1,1,1,9'd0,0,0,0,0,4'd5),
        v(0,1,1,9'h15,0,0,0,0,4'd11),  // R11 row 0x15 folds to 4
        v(0,0,0,9'h17,1,0,0,0,4'd11),  // R11 col 0x17 folds to 6
        v(1,1,1,9'd0,0,0,0,0,4'd5),
        v(0,1,1,9'd4,0,0,0,0,4'd11),
        v(0,0,1,9'd6,0,1,1,1,4'd11),   // R11 alias read =1
        v(1,1,1,9'd0,0,0,0,0,4'd5),
        v(0,1,1,9'd5,0,0,0,0,4'd2),
        v(0,0,1,9'd7,0,1,1,1,4'd3),    // R3
        v(1,0,1,9'd7,0,1,1,1,4'd6),    // R6 hold
        v(0,0,1,9'd3,0,1,1,1,4'd6),    // R6 hidden refresh keeps data
        v(1,1,1,9'd0,0,0,0,0,4'd5)     // R5
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             row_stb_n, col_stb_n, wr_en_n, wdata;
    logic [ADDR_W-1:0] mux_addr;
    logic             rdata, rdata_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mux_dram_core #(
        .ADDR_W   (ADDR_W),
        .ROW_KEEP (ROW_KEEP),
        .COL_KEEP (COL_KEEP)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_stb_n (row_stb_n),
        .col_stb_n (col_stb_n),
        .wr_en_n   (wr_en_n),
        .mux_addr  (mux_addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );

    task automatic check_bit(input string what, input int req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic drive(input logic r, input logic c, input logic w,
                         input logic [8:0] a, input logic d);
        @(negedge clk);
        row_stb_n = r;
        col_stb_n = c;
        wr_en_n   = w;
        mux_addr  = a;
        wdata     = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        row_stb_n = 1'b1;
        col_stb_n = 1'b1;
        wr_en_n   = 1'b1;
        mux_addr  = '0;
        wdata     = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check_bit("R1 oe in reset", 1, rdata_oe, 1'b0);
        check_bit("R1 data in reset", 1, rdata, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check_bit("R1 oe after reset", 1, rdata_oe, 1'b0);

        // Vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [19:0] e;
            e = VEC[i];
            drive(e[19], e[18], e[17], e[16:8], e[7]);
            check_bit($sformatf("vec %0d oe", i), int'(e[3:0]), rdata_oe, e[6]);
            if (e[4]) check_bit($sformatf("vec %0d data", i), int'(e[3:0]), rdata, e[5]);
        end

        // R1: reset in the middle of a driven read
        drive(1'b0, 1'b1, 1'b1, 9'd5, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 9'd7, 1'b0);
        check_bit("R1 pre-reset read oe", 1, rdata_oe, 1'b1);
        @(negedge clk);
        rst_n     = 1'b0;
        row_stb_n = 1'b1;
        col_stb_n = 1'b1;
        #2;
        check_bit("R1 async reset clears oe", 1, rdata_oe, 1'b0);
        check_bit("R1 async reset clears data", 1, rdata, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: controller idle after reset, column fall alone ignored
        drive(1'b1, 1'b0, 1'b1, 9'd7, 1'b0);
        check_bit("R1 idle ignores column fall", 1, rdata_oe, 1'b0);
        drive(1'b1, 1'b1, 1'b1, 9'd0, 1'b0);
        // R3: array kept across reset, read works again
        drive(1'b0, 1'b1, 1'b1, 9'd5, 1'b0);
        drive(1'b0, 1'b0, 1'b1, 9'd7, 1'b0);
        check_bit("R3 read after reset oe", 3, rdata_oe, 1'b1);
        check_bit("R3 read after reset data", 3, rdata, 1'b1);
        // R5: both strobes rise together
        drive(1'b1, 1'b1, 1'b1, 9'd0, 1'b0);
        check_bit("R5 joint rise floats", 5, rdata_oe, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule